// File: doc/BRIEF.md
# Configurable UART Frame Receiver

This block recovers asynchronous serial characters from one input line. The bit time is set at run time as a number of clock cycles. Several other settings are also chosen at run time: the character width, the parity rule, whether a stop bit is checked, the bit order, whether the line is inverted, and where inside each bit period the line is sampled. The line passes through a two-flop synchronizer. A falling edge then opens a frame, and every slot of the frame is sampled once at the chosen fraction of the bit period.

Each frame is handed over on a valid/ready output stream as a right-aligned data word together with an `ok` flag. A frame that fails any check is still delivered, with `ok` low. Three one-cycle strobes mark the reason: a start bit that did not hold low, a parity mismatch, or a stop bit that read low. The receiver cannot pause the line, so back-pressure is limited. A pending word stays stable until it is taken. If a new frame completes before then, the new frame replaces the pending word. The settings are captured when a frame opens, so rewriting them during a frame has no effect on that frame.

Top module: `uart_frame_rx`

## Requirements
- R1: Bit n of a frame (0 = start bit) is sampled floor((P-1)*pct/100) cycles after the bit slot begins, with slots P = `cfg_clks_per_bit` cycles apart (P >= 2). A `cfg_sample_pct` outside 1..99 is used as 50.
- R2: `cfg_width` selects 5 to 9 data bits (values below 5 act as 5, above 9 act as 9). The word is right-aligned in `frm_data` and its unused upper bits are 0.
- R3: With `cfg_msb_first` = 0 the first data bit received lands in `frm_data[0]`. With `cfg_msb_first` = 1 it lands in `frm_data[width-1]`.
- R4: `cfg_parity` codes: 0 none, 1 odd (data plus parity bit hold an odd number of ones), 2 even, 3 parity bit must be 0, 4 parity bit must be 1, 5 parity bit sampled but any value accepted. Codes 6 and 7 act as none.
- R5: A parity mismatch pulses `err_parity` for one cycle and delivers the frame with `frm_ok` = 0. The stop bit is still sampled and checked afterwards.
- R6: `cfg_stop` codes: 0 means no stop bit is sampled, so the frame is delivered after its last data or parity bit. 1, 2 and 3 (half, one, one and a half bits) sample the slot that follows data and parity. A 0 in that slot pulses `err_stop` and delivers the frame with its data and `frm_ok` = 0.
- R7: A start bit that samples as 1 pulses `err_start`. It delivers a frame with data 0 and `frm_ok` = 0, and the block returns to waiting for a falling edge.
- R8: With `cfg_invert` = 1 the line is complemented before edge detection and sampling, so a physically idle-low line is decoded.
- R9: The width, parity, stop and order settings, the divisor and the sample point are captured when a frame opens. Changing them during the frame does not alter that frame.
- R10: `frm_valid` stays high, and `frm_data`/`frm_ok` stay stable, until a cycle with `frm_ready` high. A frame that completes while a word is pending replaces that word.
- R11: After reset `frm_valid` and all three strobes are 0. A frame opens only on a high-to-low transition seen after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Serial input line |
| cfg_clks_per_bit | input | CPB_W | Clock cycles per bit (P >= 2) |
| cfg_width | input | 4 | Data bits per character, 5..9 |
| cfg_parity | input | 3 | Parity rule code (R4) |
| cfg_stop | input | 2 | Stop length code (R6) |
| cfg_msb_first | input | 1 | 1 = first data bit is the most significant |
| cfg_invert | input | 1 | 1 = complement the line |
| cfg_sample_pct | input | PCT_W | Sample point in percent of a bit period |
| frm_valid | output | 1 | Output word pending |
| frm_ready | input | 1 | Consumer takes the word |
| frm_data | output | DATA_W | Received data word, right-aligned |
| frm_ok | output | 1 | 1 = frame passed all checks |
| err_start | output | 1 | One-cycle strobe: start bit sampled high |
| err_parity | output | 1 | One-cycle strobe: parity mismatch |
| err_stop | output | 1 | One-cycle strobe: stop bit sampled low |

## Verification
Frames are sent with asymmetric data values at several widths and in both bit orders, so that swapped or shifted bits give a different word. Each data bit can carry the opposite value in its first 40% of the slot. The decoded word then shows whether sampling happens early (complemented word) or near mid-bit (true word), and this is done for in-range and fallback sample settings. Parity frames are sent both correct and with the parity bit flipped under each rule. One frame has both a bad parity bit and a low stop bit, to show that the stop check still runs after a parity failure. A short low glitch, an inverted line, a mid-frame settings change and a second frame sent over an untaken word cover the start check, inversion, capture and overwrite behaviour.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    PAR_NONE   = 3'd0,
    PAR_ODD    = 3'd1,
    PAR_EVEN   = 3'd2,
    PAR_ZERO   = 3'd3,
    PAR_ONE    = 3'd4,
    PAR_IGNORE = 3'd5
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_e;

  localparam int PCT_FALLBACK = 50;
  localparam int MIN_WIDTH    = 5;

  function automatic par_mode_e decode_parity(input logic [2:0] code);
    case (code)
      3'd1:    return PAR_ODD;
      3'd2:    return PAR_EVEN;
      3'd3:    return PAR_ZERO;
      3'd4:    return PAR_ONE;
      3'd5:    return PAR_IGNORE;
      default: return PAR_NONE;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic invert,
  output logic line_now,
  output logic line_dly,
  output logic fall
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   dly_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], line_in};
  end

  assign line_now = chain_q[SYNC_STAGES-1] ^ invert;

  // Reset low so that no edge is seen until the line has read high once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= 1'b0;
    else        dly_q <= line_now;
  end

  assign line_dly = dly_q;
  assign fall     = dly_q & ~line_now;

endmodule

// File: rtl/uart_rx_timer.sv
module uart_rx_timer #(
  parameter int CPB_W = 16,
  parameter int PCT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [CPB_W-1:0] cfg_cpb,
  input  logic [PCT_W-1:0] cfg_pct,
  output logic             tick
);

  localparam int PROD_W = CPB_W + PCT_W;

  logic [PCT_W-1:0]  pct_eff;
  logic [CPB_W-1:0]  cpb_m1;
  logic [PROD_W-1:0] prod;
  logic [CPB_W-1:0]  off_c;

  logic [CPB_W-1:0]  period_q;
  logic [CPB_W-1:0]  wait_q;
  logic [CPB_W-1:0]  off_q;

  always_comb begin
    if (cfg_pct >= PCT_W'(1) && cfg_pct <= PCT_W'(99)) pct_eff = cfg_pct;
    else                                                pct_eff = PCT_W'(uart_rx_pkg::PCT_FALLBACK);
    cpb_m1 = cfg_cpb - CPB_W'(1);
    prod   = PROD_W'(cpb_m1) * PROD_W'(pct_eff);
    off_c  = CPB_W'(prod / PROD_W'(100));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      wait_q   <= '0;
      off_q    <= '0;
    end else if (load) begin
      period_q <= cfg_cpb;
      wait_q   <= off_c;
      off_q    <= off_c;
    end else if (run) begin
      if (wait_q == '0) wait_q <= period_q - CPB_W'(1);
      else              wait_q <= wait_q - CPB_W'(1);
    end
  end

  assign tick = run && (wait_q == '0);

  AST_OFFSET_INSIDE_BIT: assert property (@(posedge clk) disable iff (!rst_n) run |-> (off_q < period_q)) else $error("sample offset outside bit"); // R1
  AST_ONE_SAMPLE_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n) (tick && period_q > CPB_W'(1) && !load) |=> !tick) else $error("two samples in one slot"); // R1

endmodule

// File: rtl/uart_rx_parity.sv
module uart_rx_parity
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  par_mode_e         mode,
  input  logic [DATA_W-1:0] data,
  input  logic              pbit,
  output logic              mismatch
);

  logic ones_odd;

  always_comb begin
    ones_odd = ^data;
    case (mode)
      PAR_ODD:  mismatch = (pbit == ones_odd);
      PAR_EVEN: mismatch = (pbit != ones_odd);
      PAR_ZERO: mismatch = pbit;
      PAR_ONE:  mismatch = ~pbit;
      default:  mismatch = 1'b0;
    endcase
  end

endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int CPB_W       = 16,
  parameter int DATA_W      = 9,
  parameter int PCT_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_in,
  input  logic [CPB_W-1:0]  cfg_clks_per_bit,
  input  logic [3:0]        cfg_width,
  input  logic [2:0]        cfg_parity,
  input  logic [1:0]        cfg_stop,
  input  logic              cfg_msb_first,
  input  logic              cfg_invert,
  input  logic [PCT_W-1:0]  cfg_sample_pct,
  output logic              frm_valid,
  input  logic              frm_ready,
  output logic [DATA_W-1:0] frm_data,
  output logic              frm_ok,
  output logic              err_start,
  output logic              err_parity,
  output logic              err_stop
);

  localparam int CNT_W = 4;

  logic line_now, line_dly, fall, tick, load, run, par_bad;

  rx_state_e         st_q, st_d;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              ok_q, ok_d;

  logic [CNT_W-1:0]  w_q;
  par_mode_e         par_q;
  logic              stop_en_q;
  logic              msb_q;

  logic              deliver, dlv_ok, dlv_zero;
  logic [DATA_W-1:0] dlv_data;
  logic              se_d, pe_d, te_d;
  logic [CNT_W-1:0]  w_clamped;

  uart_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .invert(cfg_invert),
    .line_now(line_now), .line_dly(line_dly), .fall(fall)
  );

  uart_rx_timer #(.CPB_W(CPB_W), .PCT_W(PCT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .run(run),
    .cfg_cpb(cfg_clks_per_bit), .cfg_pct(cfg_sample_pct), .tick(tick)
  );

  uart_rx_parity #(.DATA_W(DATA_W)) u_par (
    .mode(par_q), .data(sh_q), .pbit(line_dly), .mismatch(par_bad)
  );

  function automatic logic [DATA_W-1:0] order_bits(input logic [DATA_W-1:0] s,
                                                   input logic [CNT_W-1:0] n,
                                                   input logic msb);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(n)) r[i] = msb ? s[int'(n) - 1 - i] : s[i];
    end
    return r;
  endfunction

  always_comb begin
    if (cfg_width < CNT_W'(MIN_WIDTH))   w_clamped = CNT_W'(MIN_WIDTH);
    else if (cfg_width > CNT_W'(DATA_W)) w_clamped = CNT_W'(DATA_W);
    else                                 w_clamped = cfg_width;
  end

  assign run = (st_q != ST_IDLE);

  // Frame sequencer
  always_comb begin
    st_d     = st_q;
    idx_d    = idx_q;
    sh_d     = sh_q;
    ok_d     = ok_q;
    load     = 1'b0;
    deliver  = 1'b0;
    dlv_ok   = 1'b0;
    dlv_zero = 1'b0;
    se_d     = 1'b0;
    pe_d     = 1'b0;
    te_d     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (fall) begin
          load  = 1'b1;
          st_d  = ST_START;
          sh_d  = '0;
          idx_d = '0;
          ok_d  = 1'b1;
        end
      end
      ST_START: begin
        if (tick) begin
          if (line_dly) begin
            se_d     = 1'b1;
            deliver  = 1'b1;
            dlv_zero = 1'b1;
            st_d     = ST_IDLE;
          end else begin
            st_d = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (tick) begin
          sh_d[idx_q] = line_dly;
          if (idx_q == w_q - CNT_W'(1)) begin
            if (par_q != PAR_NONE) begin
              st_d = ST_PARITY;
            end else if (stop_en_q) begin
              st_d = ST_STOP;
            end else begin
              deliver = 1'b1;
              dlv_ok  = ok_q;
              st_d    = ST_IDLE;
            end
          end else begin
            idx_d = idx_q + CNT_W'(1);
          end
        end
      end
      ST_PARITY: begin
        if (tick) begin
          if (par_bad) begin
            pe_d = 1'b1;
            ok_d = 1'b0;
          end
          if (stop_en_q) begin
            st_d = ST_STOP;
          end else begin
            deliver = 1'b1;
            dlv_ok  = ok_d;
            st_d    = ST_IDLE;
          end
        end
      end
      ST_STOP: begin
        if (tick) begin
          if (!line_dly) begin
            te_d = 1'b1;
            ok_d = 1'b0;
          end
          deliver = 1'b1;
          dlv_ok  = ok_d;
          st_d    = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (dlv_zero) dlv_data = '0;
    else          dlv_data = order_bits(sh_d, w_q, msb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      sh_q  <= '0;
      ok_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      ok_q  <= ok_d;
    end
  end

  // Settings snapshot taken as the frame opens
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q       <= CNT_W'(MIN_WIDTH);
      par_q     <= PAR_NONE;
      stop_en_q <= 1'b1;
      msb_q     <= 1'b0;
    end else if (load) begin
      w_q       <= w_clamped;
      par_q     <= decode_parity(cfg_parity);
      stop_en_q <= (cfg_stop != 2'd0);
      msb_q     <= cfg_msb_first;
    end
  end

  // Output stream register and error strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_valid  <= 1'b0;
      frm_data   <= '0;
      frm_ok     <= 1'b0;
      err_start  <= 1'b0;
      err_parity <= 1'b0;
      err_stop   <= 1'b0;
    end else begin
      if (deliver) begin
        frm_valid <= 1'b1;
        frm_data  <= dlv_data;
        frm_ok    <= dlv_ok;
      end else if (frm_ready) begin
        frm_valid <= 1'b0;
      end
      err_start  <= se_d;
      err_parity <= pe_d;
      err_stop   <= te_d;
    end
  end

  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (frm_valid && !frm_ready && !deliver) |=> (frm_valid && $stable(frm_data) && $stable(frm_ok))) else $error("pending word changed"); // R10
  AST_START_ERR_FRAME: assert property (@(posedge clk) disable iff (!rst_n) err_start |-> (frm_valid && !frm_ok && frm_data == '0)) else $error("start error frame wrong"); // R7
  AST_START_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n) err_start |-> (st_q == ST_IDLE)) else $error("not idle after start error"); // R7
  AST_STOP_ERR_FRAME: assert property (@(posedge clk) disable iff (!rst_n) err_stop |-> (frm_valid && !frm_ok)) else $error("stop error frame not flagged"); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({err_start, err_parity, err_stop})) else $error("strobes overlap"); // R5

endmodule

// File: tb/sim_uart_frame_rx.sv
`timescale 1ns/1ps
module sim_uart_frame_rx;

  localparam int CPB_W  = 16;
  localparam int DATA_W = 9;
  localparam int PCT_W  = 7;
  localparam int P      = 20;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              line_in = 1'b1;
  logic [CPB_W-1:0]  cfg_cpb = CPB_W'(P);
  logic [3:0]        cfg_width = 4'd8;
  logic [2:0]        cfg_parity = 3'd0;
  logic [1:0]        cfg_stop = 2'd2;
  logic              cfg_msb = 1'b0;
  logic              cfg_inv = 1'b0;
  logic [PCT_W-1:0]  cfg_pct = 7'd50;
  logic              frm_ready = 1'b0;
  logic              frm_valid, frm_ok, err_start, err_parity, err_stop;
  logic [DATA_W-1:0] frm_data;

  int checks = 0;
  int errors = 0;
  int n_se = 0, n_pe = 0, n_te = 0;

  always #2.5 clk = ~clk;

  uart_frame_rx #(.CPB_W(CPB_W), .DATA_W(DATA_W), .PCT_W(PCT_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .cfg_clks_per_bit(cfg_cpb),
    .cfg_width(cfg_width), .cfg_parity(cfg_parity), .cfg_stop(cfg_stop),
    .cfg_msb_first(cfg_msb), .cfg_invert(cfg_inv), .cfg_sample_pct(cfg_pct),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data), .frm_ok(frm_ok),
    .err_start(err_start), .err_parity(err_parity), .err_stop(err_stop)
  );

  always @(posedge clk) begin
    if (err_start)  n_se++;
    if (err_parity) n_pe++;
    if (err_stop)   n_te++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_errs();
    n_se = 0; n_pe = 0; n_te = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic slot(input bit v, input bit ev, input int elen);
    for (int c = 0; c < P; c++) begin
      @(negedge clk);
      line_in = ((c < elen) ? ev : v) ^ cfg_inv;
    end
  endtask

  function automatic bit par_bit(input int mode, input logic [8:0] d, input int n);
    logic [8:0] m;
    m = d & 9'((1 << n) - 1);
    case (mode)
      1: return ~(^m);
      2: return ^m;
      4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic send(input logic [8:0] d, input int n, input bit msb, input int pmode,
                      input bit pflip, input bit stopv, input int elen);
    slot(1'b0, 1'b0, 0);
    for (int k = 0; k < n; k++) begin
      bit b;
      b = msb ? d[n-1-k] : d[k];
      slot(b, ~b, elen);
    end
    if (pmode >= 1 && pmode <= 5) slot(par_bit(pmode, d, n) ^ pflip, 1'b0, 0);
    slot(stopv, 1'b0, 0);
    slot(1'b1, 1'b1, 0);
  endtask

  task automatic expect_frame(input string req, input logic [8:0] d, input bit ok);
    int w;
    w = 0;
    while (!frm_valid && w < 4 * P) begin
      @(negedge clk);
      w++;
    end
    chk(req, "valid", int'(frm_valid), 1);
    chk(req, "data", int'(frm_data), int'(d));
    chk(req, "ok", int'(frm_ok), int'(ok));
    frm_ready = 1'b1;
    @(negedge clk);
    frm_ready = 1'b0;
    chk(req, "valid after take", int'(frm_valid), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R11", "valid at reset", int'(frm_valid), 0);
    chk("R11", "strobes at reset", int'({err_start, err_parity, err_stop}), 0);
  endtask

  task automatic t_basic();
    clear_errs();
    send(9'h0A5, 8, 0, 0, 0, 1, 0);
    expect_frame("R2", 9'h0A5, 1);
    send(9'h03C, 8, 0, 0, 0, 1, 0);
    expect_frame("R2", 9'h03C, 1);
    chk("R6", "no strobes", n_se + n_pe + n_te, 0);
  endtask

  task automatic t_widths();
    cfg_width = 4'd5;
    send(9'h015, 5, 0, 0, 0, 1, 0);
    expect_frame("R2 width5", 9'h015, 1);
    cfg_width = 4'd9;
    send(9'h1A5, 9, 0, 0, 0, 1, 0);
    expect_frame("R2 width9", 9'h1A5, 1);
    cfg_width = 4'd8;
  endtask

  task automatic t_order();
    cfg_msb = 1'b1;
    send(9'h0C1, 8, 1, 0, 0, 1, 0);
    expect_frame("R3 msb8", 9'h0C1, 1);
    cfg_width = 4'd7;
    send(9'h04B, 7, 1, 0, 0, 1, 0);
    expect_frame("R3 msb7", 9'h04B, 1);
    cfg_width = 4'd8;
    cfg_msb = 1'b0;
  endtask

  task automatic t_parity();
    cfg_width = 4'd9;
    for (int m = 1; m <= 4; m++) begin
      clear_errs();
      cfg_parity = 3'(m);
      send(9'h1A5, 9, 0, m, 0, 1, 0);
      expect_frame("R4 good", 9'h1A5, 1);
      chk("R4", "no parity strobe", n_pe, 0);
    end
    clear_errs();
    cfg_parity = 3'd5;
    send(9'h1A5, 9, 0, 5, 1, 1, 0);
    expect_frame("R4 ignore", 9'h1A5, 1);
    chk("R4", "ignore strobe", n_pe, 0);
    cfg_width = 4'd8;
    clear_errs();
    cfg_parity = 3'd2;
    send(9'h033, 8, 0, 2, 1, 1, 0);
    expect_frame("R5 even bad", 9'h033, 0);
    chk("R5", "parity strobe", n_pe, 1);
    clear_errs();
    cfg_parity = 3'd1;
    send(9'h012, 8, 0, 1, 1, 0, 0);
    expect_frame("R5 bad parity and stop", 9'h012, 0);
    chk("R5", "parity strobe", n_pe, 1);
    chk("R5", "stop still checked", n_te, 1);
    cfg_parity = 3'd0;
  endtask

  task automatic t_stop();
    clear_errs();
    send(9'h012, 8, 0, 0, 0, 0, 0);
    expect_frame("R6 stop low", 9'h012, 0);
    chk("R6", "stop strobe", n_te, 1);
    clear_errs();
    cfg_stop = 2'd0;
    send(9'h035, 8, 0, 0, 0, 0, 0);
    expect_frame("R6 no stop", 9'h035, 1);
    chk("R6", "no stop strobe", n_te, 0);
    cfg_stop = 2'd2;
  endtask

  task automatic t_start_glitch();
    clear_errs();
    repeat (3) begin @(negedge clk); line_in = 1'b0; end
    repeat (2 * P) begin @(negedge clk); line_in = 1'b1; end
    chk("R7", "start strobe", n_se, 1);
    expect_frame("R7 glitch", 9'h000, 0);
    send(9'h05A, 8, 0, 0, 0, 1, 0);
    expect_frame("R7 recover", 9'h05A, 1);
  endtask

  task automatic t_invert();
    rst_n = 1'b0;
    cfg_inv = 1'b1;
    line_in = 1'b0;
    do_reset();
    send(9'h096, 8, 0, 0, 0, 1, 0);
    expect_frame("R8 inverted", 9'h096, 1);
    rst_n = 1'b0;
    cfg_inv = 1'b0;
    line_in = 1'b1;
    do_reset();
  endtask

  task automatic t_sample_point();
    cfg_pct = 7'd10;
    send(9'h0A5, 8, 0, 0, 0, 1, 8);
    expect_frame("R1 pct10 early", 9'h05A, 1);
    cfg_pct = 7'd50;
    send(9'h0A5, 8, 0, 0, 0, 1, 8);
    expect_frame("R1 pct50", 9'h0A5, 1);
    cfg_pct = 7'd99;
    send(9'h0A5, 8, 0, 0, 0, 1, 8);
    expect_frame("R1 pct99", 9'h0A5, 1);
    cfg_pct = 7'd0;
    send(9'h0A5, 8, 0, 0, 0, 1, 8);
    expect_frame("R1 pct0 fallback", 9'h0A5, 1);
    cfg_pct = 7'd120;
    send(9'h0A5, 8, 0, 0, 0, 1, 8);
    expect_frame("R1 pct120 fallback", 9'h0A5, 1);
    cfg_pct = 7'd50;
  endtask

  task automatic t_capture();
    clear_errs();
    fork
      send(9'h0C3, 8, 0, 0, 0, 1, 0);
      begin
        repeat (3 * P) @(negedge clk);
        cfg_width = 4'd5;
        cfg_parity = 3'd2;
        cfg_msb = 1'b1;
      end
    join
    expect_frame("R9 capture", 9'h0C3, 1);
    chk("R9", "no parity strobe", n_pe, 0);
    cfg_width = 4'd8;
    cfg_parity = 3'd0;
    cfg_msb = 1'b0;
  endtask

  task automatic t_backpressure();
    send(9'h011, 8, 0, 0, 0, 1, 0);
    repeat (30) @(negedge clk);
    chk("R10", "held valid", int'(frm_valid), 1);
    chk("R10", "held data", int'(frm_data), 9'h011);
    send(9'h022, 8, 0, 0, 0, 1, 0);
    expect_frame("R10 overwrite", 9'h022, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog expired: actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_widths();
    t_order();
    t_parity();
    t_stop();
    t_start_glitch();
    t_invert();
    t_sample_point();
    t_capture();
    t_backpressure();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule